// File: doc/BRIEF.md
# Chained-Interval Watchdog Timer

This block is a watchdog that runs on its own slow clock and takes a 32-bit timeout in milliseconds. Its counter can only run a fixed set of power-of-four lengths. To reach any requested time, the block turns the milliseconds into a clock count. It then runs a chain of those fixed lengths back to back, always picking the longest one that still fits in what is left. Every link of the chain except the last ends with a short interrupt pulse, and the block moves on by itself. Only the end of the last link may reset the system, and it does so a fixed number of clocks later.

Software-side logic drives three one-cycle strobes. Configure loads a new timeout and starts a chain. Kick restarts the chain from the stored timeout. Stop disables the watchdog and cancels any reset that is pending. A configure request with a value of zero is refused and flagged.

Top module: `seg_watchdog`

## Requirements
- R1: A configure request with a nonzero value `ms` stores `(ms * CLK_HZ + 500) / 1000` clocks, with integer division. This is the millisecond value rounded to the nearest clock.
- R2: The available link lengths are 16·4^i clocks for i = 0..N_SEG-1 (16, 64, 256, 1024, 4096, 16384, 65536, 262144 by default). Each new link takes the longest length that is not greater than the clocks remaining, and subtracts that length from the remainder.
- R3: When 1 to 15 clocks remain, the next link is 16 clocks long and the remainder becomes zero.
- R4: When a link that leaves a nonzero remainder expires, `tmo_irq_o` is high for one cycle, starting one cycle after the expiry edge. The next link starts at that same edge and `sys_rst_o` stays low.
- R5: Only the link that brought the remainder to zero can reset the system. `sys_rst_o` is a one-cycle pulse that appears RST_DLY (default 3) clocks after that link expires. A chain that totals T clocks therefore pulses `sys_rst_o` in the cycle after edge E+T+RST_DLY, where E is the edge of the configure or kick.
- R6: A configure request with `cfg_ms_i` = 0 raises `cfg_err_o` for one cycle after that edge. It does not change the stored timeout or the running chain.
- R7: A kick while the watchdog is running reloads the remainder from the stored timeout and starts a fresh chain at that edge.
- R8: Stop has priority over every other request. It disables the watchdog and cancels a pending reset. After a stop there is no interrupt and no reset, and kicks are ignored until the next valid configure.
- R9: A valid configure while the watchdog is running, or while a reset is pending, replaces the stored timeout and starts a fresh chain at once. It cancels any pending reset.
- R10: After the last link expires the watchdog is idle. No further interrupt or reset occurs until a new valid configure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Watchdog clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 1 | Configure strobe, one cycle |
| cfg_ms_i | input | MS_W | Timeout in milliseconds, sampled with `cfg_i` |
| kick_i | input | 1 | Kick strobe: restart the chain from the stored timeout |
| stop_i | input | 1 | Stop strobe: disable and cancel a pending reset |
| tmo_irq_o | output | 1 | One-cycle pulse at the end of each non-final link |
| cfg_err_o | output | 1 | One-cycle pulse after a configure request with value zero |
| sys_rst_o | output | 1 | One-cycle delayed system reset pulse |

## Verification
The bench uses a clock rate of 10700 Hz so that rounding is visible. A timeout of 15 ms has to give 161 clocks and a chain of 176 clocks. A design that truncates instead of rounding would give 160 clocks and reset 16 cycles early. The bench checks chains that end in a short residual link and one that starts with a 1024-clock link. A wrong choice of link or a missed residual shows up as a shifted reset cycle or a wrong interrupt count. Other cases cover a zero-valued configure in the middle of a chain, a kick late in a long link, a reconfigure in the middle of a chain, and a stop during the reset delay. A design that lets a refused configure through, keeps counting from the old link, or lets a reset that was already armed escape would pulse `sys_rst_o` at the wrong cycle or when it should not pulse at all.

// File: rtl/seg_wdt_pkg.sv
package seg_wdt_pkg;

   // exponent of link length for index idx
   function automatic int unsigned seg_exp(input int unsigned idx,
                                           input int unsigned base,
                                           input int unsigned step);
      return base + idx * step;
   endfunction

endpackage

// File: rtl/seg_wdt_conv.sv
module seg_wdt_conv #(
   parameter int unsigned MS_W   = 32,
   parameter int unsigned CLK_HZ = 10000,
   parameter int unsigned CW     = 47
) (
   input  logic [MS_W-1:0] ms_i,
   output logic [CW-1:0]   clks_o
);
   localparam int unsigned PW = CW + 10;

   logic [PW-1:0] prod;
   logic [PW-1:0] quot;

   always_comb begin
      prod   = PW'(ms_i) * PW'(CLK_HZ) + PW'(500);
      quot   = prod / PW'(1000);
      clks_o = CW'(quot);
   end
endmodule

// File: rtl/seg_wdt_pick.sv
module seg_wdt_pick
   import seg_wdt_pkg::*;
#(
   parameter int unsigned CW       = 47,
   parameter int unsigned N_SEG    = 8,
   parameter int unsigned BASE_EXP = 4,
   parameter int unsigned EXP_STEP = 2,
   parameter int unsigned SW       = (N_SEG > 1) ? $clog2(N_SEG) : 1
) (
   input  logic [CW-1:0] avail_i,
   output logic [SW-1:0] sel_o,
   output logic [CW-1:0] left_o,
   output logic          last_o
);
   logic [N_SEG-1:0] fit;

   for (genvar g = 0; g < N_SEG; g++) begin : g_fit
      localparam int unsigned E = BASE_EXP + g * EXP_STEP;
      assign fit[g] = (avail_i >= (CW'(1) << E));
   end

   always_comb begin
      sel_o = '0;
      for (int i = 0; i < N_SEG; i++) begin
         if (fit[i]) sel_o = SW'(i);
      end
      if (fit[0]) left_o = avail_i - (CW'(1) << seg_exp(32'(sel_o), BASE_EXP, EXP_STEP));
      else        left_o = '0;
      last_o = (left_o == '0);
   end

   // R2: the chosen length fits and the next longer one does not
   always_comb begin
      if (fit[0]) begin
         p_pick_fits_r2: assert ((CW'(1) << seg_exp(32'(sel_o), BASE_EXP, EXP_STEP)) <= avail_i);
         if (32'(sel_o) + 1 < N_SEG)
            p_pick_largest_r2: assert (avail_i < (CW'(1) << seg_exp(32'(sel_o) + 1, BASE_EXP, EXP_STEP)));
      end
   end
endmodule

// File: rtl/seg_wdt_count.sv
module seg_wdt_count
   import seg_wdt_pkg::*;
#(
   parameter int unsigned N_SEG    = 8,
   parameter int unsigned BASE_EXP = 4,
   parameter int unsigned EXP_STEP = 2,
   parameter int unsigned SW       = (N_SEG > 1) ? $clog2(N_SEG) : 1,
   parameter int unsigned MW       = BASE_EXP + (N_SEG - 1) * EXP_STEP
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic [SW-1:0] sel_i,
   input  logic          run_i,
   output logic          expire_o
);
   logic [SW-1:0] sel_q;
   logic [MW-1:0] cnt_q;
   logic [MW:0]   len;
   logic [MW-1:0] last_cnt;

   always_comb begin
      len      = (MW + 1)'(1) << seg_exp(32'(sel_q), BASE_EXP, EXP_STEP);
      last_cnt = MW'(len - (MW + 1)'(1));
      expire_o = run_i && (cnt_q == last_cnt);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= '0;
         cnt_q <= '0;
      end else if (start_i) begin
         sel_q <= sel_i;
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= cnt_q + MW'(1);
      end
   end

   // R4: a running link never counts past its own length
   p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |-> (cnt_q <= last_cnt));
endmodule

// File: rtl/seg_wdt_rstdly.sv
module seg_wdt_rstdly #(
   parameter int unsigned DLY = 3,
   parameter int unsigned DW  = (DLY > 1) ? $clog2(DLY) : 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic cancel_i,
   output logic rst_o
);
   logic          pend_q;
   logic [DW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
         rst_o  <= 1'b0;
      end else begin
         rst_o <= 1'b0;
         if (cancel_i) begin
            pend_q <= 1'b0;
         end else if (arm_i) begin
            pend_q <= 1'b1;
            cnt_q  <= '0;
         end else if (pend_q) begin
            if (cnt_q == DW'(DLY - 1)) begin
               pend_q <= 1'b0;
               rst_o  <= 1'b1;
            end else begin
               cnt_q <= cnt_q + DW'(1);
            end
         end
      end
   end

   p_rst_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_o |=> !rst_o);
   p_cancel_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cancel_i |=> !rst_o);
   p_arm_not_early_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_i |=> !rst_o);
endmodule

// File: rtl/seg_watchdog.sv
module seg_watchdog
   import seg_wdt_pkg::*;
#(
   parameter int unsigned MS_W     = 32,
   parameter int unsigned CLK_HZ   = 10000,
   parameter int unsigned N_SEG    = 8,
   parameter int unsigned BASE_EXP = 4,
   parameter int unsigned EXP_STEP = 2,
   parameter int unsigned RST_DLY  = 3
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            cfg_i,
   input  logic [MS_W-1:0] cfg_ms_i,
   input  logic            kick_i,
   input  logic            stop_i,
   output logic            tmo_irq_o,
   output logic            cfg_err_o,
   output logic            sys_rst_o
);
   localparam int unsigned CW      = MS_W + $clog2(CLK_HZ) + 1;
   localparam int unsigned SW      = (N_SEG > 1) ? $clog2(N_SEG) : 1;
   localparam int unsigned MAX_EXP = BASE_EXP + (N_SEG - 1) * EXP_STEP;

   if (CLK_HZ < 500) begin : g_bad_rate
      $error("CLK_HZ below 500 can turn a nonzero timeout into zero clocks");
   end
   if (N_SEG < 1 || EXP_STEP < 1) begin : g_bad_seg
      $error("at least one link length and a nonzero exponent step required");
   end
   if (CW <= MAX_EXP) begin : g_bad_width
      $error("clock count width too narrow for the longest link");
   end

   logic          en_q, fin_q;
   logic [CW-1:0] rem_q, reload_q;
   logic [CW-1:0] conv_clks, pick_src, pick_left;
   logic [SW-1:0] pick_sel;
   logic          pick_last, seg_expire;
   logic          cfg_ok, kick_ok, next_ok, final_ok, start;

   seg_wdt_conv #(.MS_W(MS_W), .CLK_HZ(CLK_HZ), .CW(CW)) u_conv (
      .ms_i   (cfg_ms_i),
      .clks_o (conv_clks)
   );

   always_comb begin
      cfg_ok   = cfg_i && (cfg_ms_i != '0) && !stop_i;
      kick_ok  = kick_i && en_q && !stop_i && !cfg_ok;
      next_ok  = en_q && seg_expire && !fin_q && !stop_i && !cfg_ok && !kick_ok;
      final_ok = en_q && seg_expire && fin_q && !stop_i && !cfg_ok && !kick_ok;
      start    = cfg_ok || kick_ok || next_ok;
      if (cfg_ok)       pick_src = conv_clks;
      else if (kick_ok) pick_src = reload_q;
      else              pick_src = rem_q;
   end

   seg_wdt_pick #(.CW(CW), .N_SEG(N_SEG), .BASE_EXP(BASE_EXP), .EXP_STEP(EXP_STEP), .SW(SW)) u_pick (
      .avail_i (pick_src),
      .sel_o   (pick_sel),
      .left_o  (pick_left),
      .last_o  (pick_last)
   );

   seg_wdt_count #(.N_SEG(N_SEG), .BASE_EXP(BASE_EXP), .EXP_STEP(EXP_STEP), .SW(SW)) u_count (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start),
      .sel_i    (pick_sel),
      .run_i    (en_q),
      .expire_o (seg_expire)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q      <= 1'b0;
         fin_q     <= 1'b0;
         rem_q     <= '0;
         reload_q  <= '0;
         tmo_irq_o <= 1'b0;
         cfg_err_o <= 1'b0;
      end else begin
         tmo_irq_o <= next_ok;
         cfg_err_o <= cfg_i && (cfg_ms_i == '0);
         if (cfg_ok) reload_q <= conv_clks;
         if (stop_i) begin
            en_q <= 1'b0;
         end else if (start) begin
            en_q  <= 1'b1;
            rem_q <= pick_left;
            fin_q <= pick_last;
         end else if (final_ok) begin
            en_q <= 1'b0;
         end
      end
   end

   if (RST_DLY == 0) begin : g_rst_direct
      logic rst_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) rst_q <= 1'b0;
         else         rst_q <= final_ok;
      end
      assign sys_rst_o = rst_q;
   end else begin : g_rst_delayed
      seg_wdt_rstdly #(.DLY(RST_DLY)) u_dly (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .arm_i    (final_ok),
         .cancel_i (stop_i || cfg_ok),
         .rst_o    (sys_rst_o)
      );
   end

   p_stop_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> (!en_q && !tmo_irq_o));
   p_err_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i && cfg_ms_i == '0) |=> $stable(reload_q));
   p_irq_chains_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmo_irq_o |-> en_q);
   p_final_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      final_ok |=> (!en_q && !tmo_irq_o));
   p_irq_not_reset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      next_ok |=> !sys_rst_o);
endmodule

// File: tb/seg_watchdog_test.sv
`timescale 1ns/1ps
module seg_watchdog_test;
   localparam int unsigned RATE = 10700;
   localparam int unsigned DLY  = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_i = 1'b0;
   logic [31:0] cfg_ms_i = '0;
   logic        kick_i = 1'b0;
   logic        stop_i = 1'b0;
   logic        tmo_irq_o, cfg_err_o, sys_rst_o;

   int total = 0, bad = 0, cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   seg_watchdog #(.CLK_HZ(RATE), .RST_DLY(DLY)) uut (
      .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg_i), .cfg_ms_i(cfg_ms_i),
      .kick_i(kick_i), .stop_i(stop_i),
      .tmo_irq_o(tmo_irq_o), .cfg_err_o(cfg_err_o), .sys_rst_o(sys_rst_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // behavioural reference model
   longint m_reload = 0, m_rem = 0, m_left = 0;
   bit m_en = 0, m_fin = 0, m_pend = 0;
   int m_dc = 0;
   bit e_irq = 0, e_rst = 0, e_err = 0;

   function automatic longint to_clk(input longint ms);
      return (ms * RATE + 500) / 1000;
   endfunction

   task automatic m_start(input longint c);
      longint len;
      len = 16;
      for (int i = 7; i >= 0; i--) begin
         if (c >= (longint'(16) << (2 * i))) begin
            len = longint'(16) << (2 * i);
            break;
         end
      end
      m_rem  = (c < 16) ? 0 : c - len;
      m_left = len;
      m_fin  = (m_rem == 0);
      m_en   = 1'b1;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_en = 0; m_pend = 0; m_reload = 0; m_rem = 0;
         e_irq = 0; e_rst = 0; e_err = 0;
      end else begin
         e_irq = 0; e_rst = 0;
         e_err = cfg_i && (cfg_ms_i == 0);
         if (stop_i) begin
            m_en = 0; m_pend = 0;
         end else if (cfg_i && cfg_ms_i != 0) begin
            m_reload = to_clk(longint'(cfg_ms_i));
            m_pend = 0;
            m_start(m_reload);
         end else if (kick_i && m_en) begin
            m_start(m_reload);
         end else if (m_en) begin
            m_left--;
            if (m_left == 0) begin
               if (m_fin) begin
                  m_en = 0; m_pend = 1; m_dc = 0;
               end else begin
                  e_irq = 1;
                  m_start(m_rem);
               end
            end
         end else if (m_pend) begin
            if (m_dc == DLY - 1) begin
               e_rst = 1; m_pend = 0;
            end else begin
               m_dc++;
            end
         end
      end
   end

   // per-cycle comparison and event monitor
   int irq_cnt = 0, rst_cnt = 0, err_cnt = 0, rst_at = -1;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(tmo_irq_o === e_irq, "R4 tmo_irq_o vs model", tmo_irq_o, e_irq);
         chk(sys_rst_o === e_rst, "R5 sys_rst_o vs model", sys_rst_o, e_rst);
         chk(cfg_err_o === e_err, "R6 cfg_err_o vs model", cfg_err_o, e_err);
         if (tmo_irq_o) irq_cnt++;
         if (sys_rst_o) begin rst_cnt++; rst_at = cyc; end
         if (cfg_err_o) err_cnt++;
      end
   end

   task automatic clr_mon();
      irq_cnt = 0; rst_cnt = 0; err_cnt = 0; rst_at = -1;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_cfg(input int ms, output int edge_no);
      @(negedge clk);
      cfg_i = 1'b1; cfg_ms_i = ms; edge_no = cyc + 1;
      @(negedge clk);
      cfg_i = 1'b0; cfg_ms_i = '0;
   endtask

   task automatic do_kick(output int edge_no);
      @(negedge clk);
      kick_i = 1'b1; edge_no = cyc + 1;
      @(negedge clk);
      kick_i = 1'b0;
   endtask

   task automatic do_stop();
      @(negedge clk);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   initial begin
      int e, e2;
      wait_cyc(3);
      chk(tmo_irq_o == 0 && sys_rst_o == 0 && cfg_err_o == 0, "R10 reset state idle",
          {tmo_irq_o, sys_rst_o, cfg_err_o}, 0);
      @(negedge clk); rst_n = 1'b1;

      // R3 R5: 1 ms -> 11 clocks -> one 16-clock final link
      clr_mon(); do_cfg(1, e); wait_cyc(30);
      chk(rst_at == e + 16 + DLY, "R3 R5 reset cycle for 1 ms", rst_at, e + 16 + DLY);
      chk(irq_cnt == 0, "R5 no interrupt on single link", irq_cnt, 0);

      // R1 R4: 15 ms -> 161 clocks (rounded) -> 64,64,16,16,16
      clr_mon(); do_cfg(15, e); wait_cyc(200);
      chk(rst_at == e + 176 + DLY, "R1 rounding gives 176-clock chain", rst_at, e + 176 + DLY);
      chk(irq_cnt == 4, "R4 interrupts for 15 ms chain", irq_cnt, 4);
      chk(rst_cnt == 1, "R10 exactly one reset pulse", rst_cnt, 1);

      // R6 R10: zero config refused while idle
      clr_mon(); do_cfg(0, e); wait_cyc(60);
      chk(err_cnt == 1, "R6 error pulse for zero", err_cnt, 1);
      chk(rst_cnt == 0 && irq_cnt == 0, "R10 idle after refused config", rst_cnt + irq_cnt, 0);

      // R6: zero config in mid-chain leaves the chain alone (428 -> 432 clocks)
      clr_mon(); do_cfg(40, e); wait_cyc(200); do_cfg(0, e2); wait_cyc(300);
      chk(rst_at == e + 432 + DLY, "R6 chain unchanged by zero config", rst_at, e + 432 + DLY);
      chk(irq_cnt == 5, "R2 interrupts for 40 ms chain", irq_cnt, 5);

      // R7 R2: 200 ms -> 2140 clocks -> 1024,1024,64,16,16; kick late in first link
      clr_mon(); do_cfg(200, e); wait_cyc(900); do_kick(e2); wait_cyc(2200);
      chk(rst_at == e2 + 2144 + DLY, "R7 kick restarts the chain", rst_at, e2 + 2144 + DLY);
      chk(irq_cnt == 4, "R2 interrupts after kick", irq_cnt, 4);

      // R9: reconfigure mid-chain to 1 ms
      clr_mon(); do_cfg(40, e); wait_cyc(100); do_cfg(1, e2); wait_cyc(500);
      chk(rst_at == e2 + 16 + DLY, "R9 reconfigure restarts with new value", rst_at, e2 + 16 + DLY);
      chk(rst_cnt == 1, "R9 single reset after reconfigure", rst_cnt, 1);

      // R8: stop, then kick is ignored
      clr_mon(); do_cfg(1, e); wait_cyc(5); do_stop(); wait_cyc(10); do_kick(e2); wait_cyc(60);
      chk(rst_cnt == 0 && irq_cnt == 0, "R8 stop then kick stays silent", rst_cnt + irq_cnt, 0);

      // R8: stop during the reset delay cancels the reset
      clr_mon(); do_cfg(1, e); wait_cyc(15);
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      wait_cyc(30);
      chk(rst_cnt == 0, "R8 stop cancels pending reset", rst_cnt, 0);

      // R9: reconfigure during the reset delay cancels and restarts
      clr_mon(); do_cfg(1, e); wait_cyc(16); do_cfg(1, e2); wait_cyc(40);
      chk(rst_cnt == 1 && rst_at == e2 + 16 + DLY, "R9 reconfigure in delay window",
          rst_at, e2 + 16 + DLY);

      finish_run();
   end
endmodule